// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a cycle-accurate behavioural model of a synchronous static RAM with a two-bit burst counter. Every control, address and write-data input is sampled on the rising clock edge. Read data comes straight from the array location held in the address register, with no output register in the path, so a read is visible in the same clock period as the edge that sampled its address. The output enable acts at once, with no clock involved.

An access starts with one of two address-start strobes. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, chosen by the write enables. Later cycles either step the burst address or hold it. The step order is linear or interleaved within an aligned group of four words, chosen by a mode input. Three chip enables select the device. Writes can cover all byte lanes or only the lanes chosen by per-lane enables. A sleep input freezes the whole device and keeps its state.

The array depth and the number of byte lanes are parameters. Each lane holds 8 data bits plus an optional parity bit.

Top module: `burst_sram`

## Requirements
- R1: The device is selected only when `enA_n` is 0, `enB` is 1 and `enC_n` is 0. Any other combination on a start cycle deselects it.
- R2: A sampled edge where `startCtrl_n` is 0, or where `startProc_n` and `enA_n` are both 0, begins a burst at `addrIn`, provided the device is selected.
- R3: On a later edge with both start strobes inactive and `advance_n` at 0, the burst counter k increases by one and wraps after 3. The address bits above bit 1 are kept. The low two bits become (start + k) mod 4 when `seqLinear` is 1, and start XOR k when `seqLinear` is 0.
- R4: On such an edge with `advance_n` at 1, the access reuses the current address. This applies to reads and to writes.
- R5: A start edge while the device is not selected enters a deselected state. The bus is undriven from that edge on. Later edges without a start strobe stay deselected and write nothing, until a new start edge begins a burst.
- R6: A burst begun by the processor-side strobe is a read, even if write enables are asserted. The processor-side strobe is ignored while `enA_n` is 1.
- R7: A cycle writes all lanes when `globalWr_n` is 0. Otherwise it writes the lanes whose `byteEn_n` bit is 0, and only when `byteWrMaster_n` is 0. In every other case the cycle is a read. Lane n covers data bits [8n+7:8n] and, with parity, bit 8*LANES+n.
- R8: `busDriven` is 1, and `rdData` equals the word at the last accepted address, only while three things hold: `outEn_n` is 0, the last accepted cycle was a selected read, and `sleep` is 0. At all other times `rdData` is 'z. `outEn_n` and `sleep` take effect without waiting for a clock.
- R9: While `sleep` is 1, and on the first edge after it falls, all inputs are ignored. The array contents and the burst state are kept.
- R10: After reset the device is deselected and the bus is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addrIn | input | ADDR_W | Start address of a burst |
| enA_n | input | 1 | Primary chip enable, active low |
| enB | input | 1 | Second chip enable, active high |
| enC_n | input | 1 | Third chip enable, active low |
| startProc_n | input | 1 | Processor-side start strobe (read only) |
| startCtrl_n | input | 1 | Controller-side start strobe |
| advance_n | input | 1 | Burst step request, active low |
| globalWr_n | input | 1 | Write all lanes, active low |
| byteWrMaster_n | input | 1 | Enables the per-lane write enables, active low |
| byteEn_n | input | LANES | Per-lane write enables, active low |
| wrData | input | DATA_W | Write data |
| seqLinear | input | 1 | 1: linear burst order, 0: interleaved order |
| outEn_n | input | 1 | Output enable, active low, acts at once |
| sleep | input | 1 | Power-down request, acts at once on the bus |
| rdData | output | DATA_W | Read data, 'z when not driven |
| busDriven | output | 1 | 1 while rdData is driven |

## Verification
A wrong burst counter or start address shows up on `rdData` in the very period after the edge that stepped it, because there is no output register to hide it. A stale select or read flag shows up at once as `busDriven` being asserted or missing. A spurious or mis-masked write stays in the array, with no visible sign, until that word is next read. For this reason every deselect, suspend, sleep and byte-lane case is followed by read-backs of each word it could have touched.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int MAX_LANES = 4;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_OFF,
    CYC_START_RD,
    CYC_START_WR,
    CYC_STEP,
    CYC_HOLD
  } cyc_e;

  typedef struct packed {
    logic                 writeNow;
    logic [MAX_LANES-1:0] laneMask;
    logic                 readLive;
  } strobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              enA_n,
  input  logic              enB,
  input  logic              enC_n,
  input  logic              startProc_n,
  input  logic              startCtrl_n,
  input  logic              advance_n,
  input  logic              globalWr_n,
  input  logic              byteWrMaster_n,
  input  logic [LANES-1:0]  byteEn_n,
  input  logic              seqLinear,
  input  logic              sleep,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] accAddr,
  output logic [ADDR_W-1:0] curAddr
);
  logic       active, lastRead, sleepLag;
  logic [1:0] baseLow, cnt, cntNext, lowNext;
  logic       sel, procHit, anyStart, gate, wantWrite, isWr;
  logic [MAX_LANES-1:0] laneReq;
  cyc_e       kind;

  assign sel       = !enA_n && enB && !enC_n;
  assign procHit   = !startProc_n && !enA_n;
  assign anyStart  = procHit || !startCtrl_n;
  assign gate      = sleep || sleepLag;
  assign wantWrite = !globalWr_n || (!byteWrMaster_n && (byteEn_n != '1));

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    if (g < LANES) begin : g_used
      assign laneReq[g] = !globalWr_n || (!byteWrMaster_n && !byteEn_n[g]);
    end else begin : g_unused
      assign laneReq[g] = 1'b0;
    end
  end

  always_comb begin
    if (gate)              kind = CYC_NONE;
    else if (anyStart)     kind = !sel ? CYC_OFF
                                 : procHit ? CYC_START_RD
                                 : wantWrite ? CYC_START_WR : CYC_START_RD;
    else if (!active)      kind = CYC_NONE;
    else if (!advance_n)   kind = CYC_STEP;
    else                   kind = CYC_HOLD;
  end

  assign isWr    = (kind == CYC_START_WR) ||
                   (((kind == CYC_STEP) || (kind == CYC_HOLD)) && wantWrite);
  assign cntNext = (kind == CYC_STEP) ? cnt + 2'd1 : cnt;
  assign lowNext = seqLinear ? baseLow + cntNext : baseLow ^ cntNext;

  always_comb begin
    if ((kind == CYC_START_RD) || (kind == CYC_START_WR)) accAddr = addrIn;
    else accAddr = {curAddr[ADDR_W-1:2], lowNext};
  end

  always_comb begin
    strb.writeNow = isWr;
    strb.laneMask = isWr ? laneReq : '0;
    strb.readLive = lastRead;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      lastRead <= 1'b0;
      sleepLag <= 1'b0;
      baseLow  <= '0;
      cnt      <= '0;
      curAddr  <= '0;
    end else begin
      sleepLag <= sleep;
      unique case (kind)
        CYC_OFF: begin
          active   <= 1'b0;
          lastRead <= 1'b0;
        end
        CYC_START_RD, CYC_START_WR: begin
          active   <= 1'b1;
          baseLow  <= addrIn[1:0];
          cnt      <= '0;
          curAddr  <= addrIn;
          lastRead <= !isWr;
        end
        CYC_STEP, CYC_HOLD: begin
          cnt      <= cntNext;
          curAddr  <= accAddr;
          lastRead <= !isWr;
        end
        default: ;
      endcase
    end
  end

  a_r5_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (anyStart && !sel && !gate) |=> !strb.readLive);
  a_r4_suspend_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !anyStart && advance_n && !gate) |=> $stable(curAddr));
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !anyStart && !advance_n && !gate)
      |=> curAddr[ADDR_W-1:2] == $past(curAddr[ADDR_W-1:2]));
  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> ($stable(curAddr) && $stable(strb.readLive)));
  a_r6_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (procHit && sel && !gate) |-> !strb.writeNow);
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter bit PARITY = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  strobe_t                               strb,
  input  logic [ADDR_W-1:0]                     accAddr,
  input  logic [ADDR_W-1:0]                     curAddr,
  input  logic [LANES*8+(PARITY?LANES:0)-1:0]   wrData,
  input  logic                                  outEn_n,
  input  logic                                  sleep,
  output logic [LANES*8+(PARITY?LANES:0)-1:0]   rdData,
  output logic                                  busDriven
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES*8 + (PARITY ? LANES : 0);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bitMask;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign bitMask[8*g +: 8] = {8{strb.laneMask[g]}};
    if (PARITY) begin : g_par
      assign bitMask[8*LANES + g] = strb.laneMask[g];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.writeNow)
      mem[accAddr] <= (mem[accAddr] & ~bitMask) | (wrData & bitMask);
  end

  assign busDriven = strb.readLive && !outEn_n && !sleep;
  assign rdData    = busDriven ? mem[curAddr] : 'z;

  a_r7_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
    strb.writeNow |-> (strb.laneMask != '0));
  a_r8_no_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    strb.writeNow |=> !busDriven);
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter bit PARITY = 1'b1,
  localparam int DATA_W = LANES*8 + (PARITY ? LANES : 0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              enA_n,
  input  logic              enB,
  input  logic              enC_n,
  input  logic              startProc_n,
  input  logic              startCtrl_n,
  input  logic              advance_n,
  input  logic              globalWr_n,
  input  logic              byteWrMaster_n,
  input  logic [LANES-1:0]  byteEn_n,
  input  logic [DATA_W-1:0] wrData,
  input  logic              seqLinear,
  input  logic              outEn_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdData,
  output logic              busDriven
);
  strobe_t           strb;
  logic [ADDR_W-1:0] accAddr, curAddr;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn),
    .enA_n(enA_n), .enB(enB), .enC_n(enC_n),
    .startProc_n(startProc_n), .startCtrl_n(startCtrl_n), .advance_n(advance_n),
    .globalWr_n(globalWr_n), .byteWrMaster_n(byteWrMaster_n), .byteEn_n(byteEn_n),
    .seqLinear(seqLinear), .sleep(sleep),
    .strb(strb), .accAddr(accAddr), .curAddr(curAddr)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .PARITY(PARITY)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .accAddr(accAddr), .curAddr(curAddr),
    .wrData(wrData), .outEn_n(outEn_n), .sleep(sleep),
    .rdData(rdData), .busDriven(busDriven)
  );
endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int LANES  = 2;
  localparam int DATA_W = 18;
  localparam int DEPTH  = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] addrIn;
  logic enA_n, enB, enC_n, startProc_n, startCtrl_n, advance_n;
  logic globalWr_n, byteWrMaster_n, seqLinear, outEn_n, sleep;
  logic [LANES-1:0] byteEn_n;
  logic [DATA_W-1:0] wrData, rdData;
  logic busDriven;

  logic [DATA_W-1:0] refMem [DEPTH];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .PARITY(1'b1)) u_burst_sram (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .enA_n(enA_n), .enB(enB), .enC_n(enC_n),
    .startProc_n(startProc_n), .startCtrl_n(startCtrl_n), .advance_n(advance_n),
    .globalWr_n(globalWr_n), .byteWrMaster_n(byteWrMaster_n), .byteEn_n(byteEn_n),
    .wrData(wrData), .seqLinear(seqLinear), .outEn_n(outEn_n), .sleep(sleep),
    .rdData(rdData), .busDriven(busDriven)
  );

  function automatic logic [DATA_W-1:0] pat(input int a, input int s);
    return DATA_W'((a * 1237 + s * 91 + 7) & 18'h3ffff);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkRead(input int a, input string req);
    chk(busDriven === 1'b1, req, 32'(busDriven), 32'd1);
    chk(rdData === refMem[a], req, 32'(rdData), 32'(refMem[a]));
  endtask

  task automatic idle();
    enA_n = 0; enB = 1; enC_n = 0;
    startProc_n = 1; startCtrl_n = 1; advance_n = 1;
    globalWr_n = 1; byteWrMaster_n = 1; byteEn_n = '1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr1(input int a, input logic [DATA_W-1:0] d);
    addrIn = ADDR_W'(a); startCtrl_n = 0; globalWr_n = 0; wrData = d;
    tick();
    refMem[a] = d;
    idle();
  endtask

  task automatic beginRd(input int a);
    addrIn = ADDR_W'(a); startCtrl_n = 0;
    tick();
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    idle();
    addrIn = '0; wrData = '0; seqLinear = 1; outEn_n = 0; sleep = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busDriven === 1'b0, "R10 bus idle in reset", 32'(busDriven), 0);
    rst_n = 1;
    tick();
    chk(busDriven === 1'b0, "R10 bus idle after reset", 32'(busDriven), 0);

    // R2 R8: fill every word, then read each one back with single starts
    for (int a = 0; a < DEPTH; a++) wr1(a, pat(a, 0));
    for (int a = 0; a < DEPTH; a++) begin beginRd(a); chkRead(a, "R2 R8 single read"); end

    // R3: both burst orders from every start offset, including the wrap
    for (int m = 0; m < 2; m++) begin
      seqLinear = m[0];
      for (int s = 0; s < 4; s++) begin
        beginRd(8 + s);
        chkRead(8 + s, "R3 burst first");
        for (int k = 1; k <= 4; k++) begin
          advance_n = 0;
          tick();
          chkRead(8 + (m == 1 ? ((s + k) & 3) : (s ^ (k & 3))), "R3 burst step");
        end
        idle();
      end
    end
    seqLinear = 1;

    // R7: byte-lane writes within a burst
    d = pat(99, 1);
    addrIn = 17; startCtrl_n = 0; byteWrMaster_n = 0; byteEn_n = 2'b10; wrData = d;
    tick();
    refMem[17] = (refMem[17] & ~18'h100FF) | (d & 18'h100FF);
    idle();
    chk(busDriven === 1'b0, "R8 no drive after write", 32'(busDriven), 0);
    d = pat(98, 2);
    advance_n = 0; byteWrMaster_n = 0; byteEn_n = 2'b01; wrData = d;
    tick();
    refMem[18] = (refMem[18] & ~18'h2FF00) | (d & 18'h2FF00);
    idle();
    advance_n = 0; byteWrMaster_n = 1; byteEn_n = 2'b00; wrData = pat(97, 3);
    tick();
    chkRead(19, "R7 master high means read");
    idle();
    addrIn = 20; startCtrl_n = 0; globalWr_n = 0; byteWrMaster_n = 1; wrData = pat(96, 4);
    tick();
    refMem[20] = pat(96, 4);
    idle();
    for (int a = 17; a <= 20; a++) begin beginRd(a); chkRead(a, "R7 lane readback"); end

    // R4: suspend of reads and writes
    beginRd(4);
    tick(); chkRead(4, "R4 suspend read");
    tick(); chkRead(4, "R4 suspend read again");
    globalWr_n = 0; wrData = pat(4, 5);
    tick();
    refMem[4] = pat(4, 5);
    idle();
    chk(busDriven === 1'b0, "R8 suspend write not driven", 32'(busDriven), 0);
    tick(); chkRead(4, "R4 suspend write landed");
    advance_n = 0; tick(); chkRead(5, "R4 step after suspend");
    idle();

    // R1 R5: each enable alone deselects; later cycles stay deselected and write nothing
    for (int b = 0; b < 3; b++) begin
      beginRd(0);
      addrIn = 2; startCtrl_n = 0;
      if (b == 0) enA_n = 1; else if (b == 1) enB = 0; else enC_n = 1;
      tick();
      idle();
      chk(busDriven === 1'b0, "R1 R5 deselect start", 32'(busDriven), 0);
      for (int k = 0; k < 3; k++) begin
        advance_n = k[0]; globalWr_n = 0; wrData = pat(77, k);
        tick();
        chk(busDriven === 1'b0, "R5 stays deselected", 32'(busDriven), 0);
      end
      idle();
      for (int a = 0; a < 4; a++) begin beginRd(a); chkRead(a, "R5 no write while deselected"); end
    end

    // R6: processor-side start reads despite write enables, ignored when enA_n high
    addrIn = 9; startProc_n = 0; globalWr_n = 0; wrData = pat(55, 6);
    tick();
    idle();
    chkRead(9, "R6 proc start reads");
    beginRd(12);
    startProc_n = 0; enA_n = 1; addrIn = 20; advance_n = 0;
    tick();
    idle();
    chkRead(13, "R6 proc strobe ignored");

    // R8: output enable acts without a clock
    beginRd(3);
    chkRead(3, "R8 oe low");
    outEn_n = 1; #1;
    chk(busDriven === 1'b0, "R8 oe high async", 32'(busDriven), 0);
    outEn_n = 0; #1;
    chkRead(3, "R8 oe low again");

    // R9: sleep keeps state and ignores inputs, including the recovery edge
    beginRd(24);
    sleep = 1; #1;
    chk(busDriven === 1'b0, "R9 sleep blanks bus", 32'(busDriven), 0);
    addrIn = 2; startCtrl_n = 0; globalWr_n = 0; wrData = pat(66, 7);
    tick(); tick();
    chk(busDriven === 1'b0, "R9 asleep", 32'(busDriven), 0);
    sleep = 0;
    tick();
    chkRead(24, "R9 recovery edge ignored");
    idle();
    advance_n = 0;
    tick();
    chkRead(25, "R9 burst state kept");
    idle();
    beginRd(2);
    chkRead(2, "R9 no write in sleep");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule